// File: doc/BRIEF.md
# Conflict-Fill Instruction Cache

This block sits between an instruction sequencer and a single program-memory bus. The same bus carries instruction fetches and data reads. An instruction that moves two data words reads one of them through the program-memory bus. That read takes the bus in the same cycle the sequencer wants to fetch the next instruction. The cache exists only to settle that collision.

The cache does not allocate on every miss. Ordinary fetches go straight to memory, and they neither look up nor update the cache. On a collision the cache looks up the address of the fetch that lost the bus.

- **Collision hit:** the stored word is returned, and the two-word instruction finishes without a stall.
- **Collision miss:** the block raises a stall for exactly one cycle and gives the bus to the data read. In the next cycle it fetches the instruction itself, writes the word into the cache and returns it.

The store is direct-mapped. There are 32 entries of 48-bit words, indexed by the low five bits of a 32-bit fetch address. The upper 27 bits are kept as a tag, and each entry has a valid bit.

Top module: `pmx_conflict_cache`

## Requirements
- R1: While `rst` is high at a rising edge, all entries become invalid and `instr_valid` is 0 after that edge. The first collision at any address after reset therefore misses.
- R2: A plain fetch (`fetch_req`=1, `dual_pm_req`=0, no refill in progress) behaves as follows:
  - in the same cycle it drives `pm_addr`=`fetch_addr`, `pm_rd`=1 and `pm_for_data`=0;
  - one cycle later it gives `instr_valid`=1 with `instr` equal to the `pm_rdata` of that cycle;
  - `stall` stays 0.
- R3: A plain fetch never allocates. A later collision at the same address still misses.
- R4: Whenever `dual_pm_req` is 1 outside a refill cycle, the bus serves the data read in that cycle: `pm_rd`=1, `pm_for_data`=1 and `pm_addr`=`dual_pm_addr`. This holds with or without a fetch.
- R5: A collision (`fetch_req`=1 and `dual_pm_req`=1) that misses proceeds as follows:
  - `stall` is 1 in that cycle only;
  - in the next cycle the bus reads the missed address (`pm_rd`=1, `pm_for_data`=0);
  - `instr_valid`=1 with that bus word follows one cycle after the bus read, two cycles after the collision.
- R6: After a collision miss, the fetched word is held in the entry. A later collision at the same address hits: `stall` stays 0 and the stored word appears one cycle later, even if memory has changed since.
- R7: Entries are chosen by `fetch_addr[4:0]` and tagged by `fetch_addr[31:5]`. A collision at an address with the same low bits and a different tag misses and replaces the entry, so the earlier address misses again.
- R8: Request inputs in the refill cycle are ignored. `stall` stays 0, the bus still reads the missed address, and no extra instruction is returned for them.
- R9: A plain fetch of an address that is held in the cache still returns the current memory word, not the stored one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_req | input | 1 | Sequencer requests an instruction this cycle |
| fetch_addr | input | 32 | Address of the requested instruction |
| dual_pm_req | input | 1 | Executing instruction reads a data word over the program-memory bus |
| dual_pm_addr | input | 32 | Address of that data word |
| instr_valid | output | 1 | `instr` carries a returned instruction |
| instr | output | 48 | Returned instruction word |
| stall | output | 1 | Collision missed; the sequencer holds for one cycle |
| pm_addr | output | 32 | Program-memory bus address |
| pm_rd | output | 1 | Program-memory bus read strobe |
| pm_for_data | output | 1 | Bus cycle serves a data read rather than a fetch |
| pm_rdata | input | 48 | Program-memory read data, valid in the cycle of the request |

## Verification
The hardest case to show from the ports is that a collision hit really comes from the stored entry and not from memory. On a hit the bus is busy with the data read, so a correct word alone proves nothing. The bench's memory model therefore derives every word from the address and a changeable salt. After an entry is filled, the salt is changed. A collision hit must then return the old word, while a plain fetch of the same address must return the new one. A second difficult case is a request that arrives in the one-cycle refill window. The stimulus drives a full collision with a different address there and confirms that the bus, the stall line and the result queue all ignore it. Aliased addresses that differ only above bit 4 force the replacement path.

// File: rtl/pmx_cc_pkg.sv
package pmx_cc_pkg;

    localparam int unsigned DEF_ADDR_W  = 32;
    localparam int unsigned DEF_INSTR_W = 48;
    localparam int unsigned DEF_ENTRIES = 32;

    // Sequencing state: normal operation or the one-cycle refill slot.
    typedef enum logic {
        SEQ_RUN    = 1'b0,
        SEQ_REFILL = 1'b1
    } seq_state_e;

    // Where the next returned instruction comes from.
    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_BUS   = 2'd1,
        SRC_CACHE = 2'd2
    } ret_src_e;

    // Program-memory bus control for the current cycle.
    typedef struct packed {
        logic bus_rd;
        logic for_data;
        logic use_refill_addr;
        logic use_data_addr;
    } bus_ctl_t;

    localparam bus_ctl_t BUS_IDLE   = '{bus_rd: 1'b0, for_data: 1'b0, use_refill_addr: 1'b0, use_data_addr: 1'b0};
    localparam bus_ctl_t BUS_FETCH  = '{bus_rd: 1'b1, for_data: 1'b0, use_refill_addr: 1'b0, use_data_addr: 1'b0};
    localparam bus_ctl_t BUS_DATA   = '{bus_rd: 1'b1, for_data: 1'b1, use_refill_addr: 1'b0, use_data_addr: 1'b1};
    localparam bus_ctl_t BUS_REFILL = '{bus_rd: 1'b1, for_data: 1'b0, use_refill_addr: 1'b1, use_data_addr: 1'b0};

    // A collision: fetch and program-memory data read in the same cycle,
    // counted only outside the refill slot.
    function automatic logic is_collision(input logic fetch, input logic dual, input logic refill);
        return fetch && dual && !refill;
    endfunction

    // A plain fetch that owns the bus.
    function automatic logic is_plain_fetch(input logic fetch, input logic dual, input logic refill);
        return fetch && !dual && !refill;
    endfunction

endpackage

// File: rtl/pmx_cc_tags.sv
module pmx_cc_tags #(
    parameter int unsigned ENTRIES = pmx_cc_pkg::DEF_ENTRIES,
    parameter int unsigned TAG_W   = pmx_cc_pkg::DEF_ADDR_W - $clog2(pmx_cc_pkg::DEF_ENTRIES)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [$clog2(ENTRIES)-1:0] lk_idx,
    input  logic [TAG_W-1:0]           lk_tag,
    output logic                       lk_hit,
    input  logic                       wr_en,
    input  logic [$clog2(ENTRIES)-1:0] wr_idx,
    input  logic [TAG_W-1:0]           wr_tag
);

    localparam int unsigned IDX_W = $clog2(ENTRIES);

    logic [ENTRIES-1:0] valid_vec;
    logic [TAG_W-1:0]   tag_arr [ENTRIES];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        logic             v_q;
        logic [TAG_W-1:0] t_q;
        logic             sel;

        assign sel = wr_en && (wr_idx == IDX_W'(e));

        always_ff @(posedge clk) begin
            if (rst) begin
                v_q <= 1'b0;
            end else if (sel) begin
                v_q <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (sel) begin
                t_q <= wr_tag;
            end
        end

        assign valid_vec[e] = v_q;
        assign tag_arr[e]   = t_q;
    end

    always_comb begin
        lk_hit = valid_vec[lk_idx] && (tag_arr[lk_idx] == lk_tag);
    end

endmodule

// File: rtl/pmx_cc_words.sv
module pmx_cc_words #(
    parameter int unsigned ENTRIES = pmx_cc_pkg::DEF_ENTRIES,
    parameter int unsigned WORD_W  = pmx_cc_pkg::DEF_INSTR_W
) (
    input  logic                       clk,
    input  logic [$clog2(ENTRIES)-1:0] rd_idx,
    output logic [WORD_W-1:0]          rd_word,
    input  logic                       wr_en,
    input  logic [$clog2(ENTRIES)-1:0] wr_idx,
    input  logic [WORD_W-1:0]          wr_word
);

    logic [WORD_W-1:0] mem [ENTRIES];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_idx] <= wr_word;
        end
    end

    always_comb begin
        rd_word = mem[rd_idx];
    end

endmodule

// File: rtl/pmx_cc_ctrl.sv
module pmx_cc_ctrl
    import pmx_cc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       fetch_req,
    input  logic       dual_req,
    input  logic       lk_hit,
    output logic       refill,
    output logic       stall,
    output logic       alloc_en,
    output logic       addr_capture,
    output ret_src_e   ret_src,
    output bus_ctl_t   bus
);

    seq_state_e state_q;
    seq_state_e state_d;
    logic       collide;
    logic       plain;

    always_comb begin
        refill       = (state_q == SEQ_REFILL);
        collide      = is_collision(fetch_req, dual_req, refill);
        plain        = is_plain_fetch(fetch_req, dual_req, refill);
        stall        = collide && !lk_hit;
        alloc_en     = refill;
        addr_capture = stall;
        state_d      = stall ? SEQ_REFILL : SEQ_RUN;
    end

    always_comb begin
        if (refill) begin
            ret_src = SRC_BUS;
        end else if (collide && lk_hit) begin
            ret_src = SRC_CACHE;
        end else if (plain) begin
            ret_src = SRC_BUS;
        end else begin
            ret_src = SRC_NONE;
        end
    end

    always_comb begin
        if (refill) begin
            bus = BUS_REFILL;
        end else if (dual_req) begin
            bus = BUS_DATA;
        end else if (fetch_req) begin
            bus = BUS_FETCH;
        end else begin
            bus = BUS_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_RUN;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/pmx_conflict_cache.sv
module pmx_conflict_cache
    import pmx_cc_pkg::*;
#(
    parameter int unsigned ADDR_W  = DEF_ADDR_W,
    parameter int unsigned INSTR_W = DEF_INSTR_W,
    parameter int unsigned ENTRIES = DEF_ENTRIES
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               fetch_req,
    input  logic [ADDR_W-1:0]  fetch_addr,
    input  logic               dual_pm_req,
    input  logic [ADDR_W-1:0]  dual_pm_addr,
    output logic               instr_valid,
    output logic [INSTR_W-1:0] instr,
    output logic               stall,
    output logic [ADDR_W-1:0]  pm_addr,
    output logic               pm_rd,
    output logic               pm_for_data,
    input  logic [INSTR_W-1:0] pm_rdata
);

    localparam int unsigned IDX_W = $clog2(ENTRIES);
    localparam int unsigned TAG_W = ADDR_W - IDX_W;

    logic               lk_hit;
    logic               refill_busy;
    logic               alloc_en;
    logic               addr_capture;
    ret_src_e           ret_src;
    bus_ctl_t           bus;
    logic [ADDR_W-1:0]  refill_addr_q;
    logic [INSTR_W-1:0] cache_word;
    logic [IDX_W-1:0]   lk_idx;
    logic [TAG_W-1:0]   lk_tag;
    logic [IDX_W-1:0]   wr_idx;
    logic [TAG_W-1:0]   wr_tag;

    assign lk_idx = fetch_addr[IDX_W-1:0];
    assign lk_tag = fetch_addr[ADDR_W-1:IDX_W];
    assign wr_idx = refill_addr_q[IDX_W-1:0];
    assign wr_tag = refill_addr_q[ADDR_W-1:IDX_W];

    pmx_cc_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .fetch_req    (fetch_req),
        .dual_req     (dual_pm_req),
        .lk_hit       (lk_hit),
        .refill       (refill_busy),
        .stall        (stall),
        .alloc_en     (alloc_en),
        .addr_capture (addr_capture),
        .ret_src      (ret_src),
        .bus          (bus)
    );

    pmx_cc_tags #(
        .ENTRIES (ENTRIES),
        .TAG_W   (TAG_W)
    ) u_tags (
        .clk    (clk),
        .rst    (rst),
        .lk_idx (lk_idx),
        .lk_tag (lk_tag),
        .lk_hit (lk_hit),
        .wr_en  (alloc_en),
        .wr_idx (wr_idx),
        .wr_tag (wr_tag)
    );

    pmx_cc_words #(
        .ENTRIES (ENTRIES),
        .WORD_W  (INSTR_W)
    ) u_words (
        .clk     (clk),
        .rd_idx  (lk_idx),
        .rd_word (cache_word),
        .wr_en   (alloc_en),
        .wr_idx  (wr_idx),
        .wr_word (pm_rdata)
    );

    // Missed address held for the refill slot.
    always_ff @(posedge clk) begin
        if (rst) begin
            refill_addr_q <= '0;
        end else if (addr_capture) begin
            refill_addr_q <= fetch_addr;
        end
    end

    // Bus address steering.
    always_comb begin
        pm_rd       = bus.bus_rd;
        pm_for_data = bus.for_data;
        if (bus.use_refill_addr) begin
            pm_addr = refill_addr_q;
        end else if (bus.use_data_addr) begin
            pm_addr = dual_pm_addr;
        end else if (bus.bus_rd) begin
            pm_addr = fetch_addr;
        end else begin
            pm_addr = '0;
        end
    end

    // Returned-instruction register.
    always_ff @(posedge clk) begin
        if (rst) begin
            instr_valid <= 1'b0;
            instr       <= '0;
        end else begin
            unique case (ret_src)
                SRC_BUS: begin
                    instr_valid <= 1'b1;
                    instr       <= pm_rdata;
                end
                SRC_CACHE: begin
                    instr_valid <= 1'b1;
                    instr       <= cache_word;
                end
                default: begin
                    instr_valid <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/pmx_cc_checker.sv
module pmx_cc_checker #(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned INSTR_W = 48
) (
    input logic               clk,
    input logic               rst,
    input logic               fetch_req,
    input logic [ADDR_W-1:0]  fetch_addr,
    input logic               dual_pm_req,
    input logic [ADDR_W-1:0]  dual_pm_addr,
    input logic               instr_valid,
    input logic [INSTR_W-1:0] instr,
    input logic               stall,
    input logic [ADDR_W-1:0]  pm_addr,
    input logic               pm_rd,
    input logic               pm_for_data,
    input logic [INSTR_W-1:0] pm_rdata,
    input logic               refill_busy
);

    logic rst_seen_q;

    always_ff @(posedge clk) begin
        rst_seen_q <= rst;
    end

    // R1
    always @(negedge clk) begin
        if (rst_seen_q) begin
            reset_out_chk: assert (!instr_valid);
        end
    end

    // R2
    plain_bus_chk: assert property (@(posedge clk) disable iff (rst)
        (fetch_req && !dual_pm_req && !refill_busy) |-> (pm_rd && !pm_for_data && pm_addr == fetch_addr && !stall));

    // R2
    plain_ret_chk: assert property (@(posedge clk) disable iff (rst)
        (fetch_req && !dual_pm_req && !refill_busy) |=> (instr_valid && instr == $past(pm_rdata)));

    // R4
    data_bus_chk: assert property (@(posedge clk) disable iff (rst)
        (dual_pm_req && !refill_busy) |-> (pm_rd && pm_for_data && pm_addr == dual_pm_addr));

    // R5
    stall_single_chk: assert property (@(posedge clk) disable iff (rst)
        stall |=> !stall);

    // R5
    refill_bus_chk: assert property (@(posedge clk) disable iff (rst)
        stall |=> (pm_rd && !pm_for_data && pm_addr == $past(fetch_addr)));

    // R5
    refill_ret_chk: assert property (@(posedge clk) disable iff (rst)
        stall |=> ##1 (instr_valid && instr == $past(pm_rdata)));

    // R8
    refill_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        refill_busy |-> (!stall && !pm_for_data));

endmodule

bind pmx_conflict_cache pmx_cc_checker #(
    .ADDR_W  (ADDR_W),
    .INSTR_W (INSTR_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .fetch_req    (fetch_req),
    .fetch_addr   (fetch_addr),
    .dual_pm_req  (dual_pm_req),
    .dual_pm_addr (dual_pm_addr),
    .instr_valid  (instr_valid),
    .instr        (instr),
    .stall        (stall),
    .pm_addr      (pm_addr),
    .pm_rd        (pm_rd),
    .pm_for_data  (pm_for_data),
    .pm_rdata     (pm_rdata),
    .refill_busy  (refill_busy)
);

// File: tb/tb_pmx_conflict_cache.sv
`timescale 1ns/1ps
module tb_pmx_conflict_cache;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fetch_req = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic        dual_pm_req = 1'b0;
    logic [31:0] dual_pm_addr = '0;
    logic        instr_valid;
    logic [47:0] instr;
    logic        stall;
    logic [31:0] pm_addr;
    logic        pm_rd;
    logic        pm_for_data;
    logic [47:0] pm_rdata;

    logic [15:0] salt = 16'h5a5a;
    int          cyc = 0;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    // Expected cache contents, kept from the requirements.
    bit          m_v [32];
    logic [26:0] m_t [32];
    logic [47:0] m_w [32];

    typedef struct {
        logic [47:0] w;
        int          due;
        string       rq;
    } exp_t;
    exp_t q [$];

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [47:0] word_of(input logic [31:0] a, input logic [15:0] s);
        return {a[15:0] ^ s, a};
    endfunction

    assign pm_rdata = pm_rd ? word_of(pm_addr, salt) : '0;

    pmx_conflict_cache dut (
        .clk          (clk),
        .rst          (rst),
        .fetch_req    (fetch_req),
        .fetch_addr   (fetch_addr),
        .dual_pm_req  (dual_pm_req),
        .dual_pm_addr (dual_pm_addr),
        .instr_valid  (instr_valid),
        .instr        (instr),
        .stall        (stall),
        .pm_addr      (pm_addr),
        .pm_rd        (pm_rd),
        .pm_for_data  (pm_for_data),
        .pm_rdata     (pm_rdata)
    );

    task automatic chk(input bit ok, input string rq, input logic [47:0] act, input logic [47:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", rq, act, exp, cyc);
        end
    endtask

    // Monitor: pops expected results as the design returns them.
    always @(posedge clk) begin
        #1;
        if (!rst && instr_valid) begin
            if (q.size() == 0) begin
                chk(1'b0, "R8 unexpected return", instr, 48'h0);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk(instr == e.w, e.rq, instr, e.w);
                chk(cyc == e.due, {e.rq, " timing"}, 48'(cyc), 48'(e.due));
            end
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            fetch_req   = 1'b0;
            dual_pm_req = 1'b0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        fetch_req   = 1'b0;
        dual_pm_req = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(instr_valid == 1'b0, "R1 valid in reset", 48'(instr_valid), 48'h0);
        chk(stall == 1'b0, "R1 stall in reset", 48'(stall), 48'h0);
        rst = 1'b0;
        for (int i = 0; i < 32; i++) m_v[i] = 1'b0;
    endtask

    // Driver: one request, expected result pushed for the monitor.
    task automatic do_fetch(input logic [31:0] a, input bit dual, input logic [31:0] da,
                            input bit junk, input string rq);
        logic [4:0]  ix;
        logic [26:0] tg;
        bit          hit;
        exp_t        e;
        ix = a[4:0];
        tg = a[31:5];
        @(negedge clk);
        fetch_req    = 1'b1;
        fetch_addr   = a;
        dual_pm_req  = dual;
        dual_pm_addr = da;
        hit = dual && m_v[ix] && (m_t[ix] == tg);
        #1;
        chk(stall == (dual && !hit), {rq, " stall"}, 48'(stall), 48'(dual && !hit));
        if (dual) begin
            chk(pm_rd && pm_for_data && pm_addr == da, {rq, " R4 data bus"}, 48'(pm_addr), 48'(da));
        end else begin
            chk(pm_rd && !pm_for_data && pm_addr == a, {rq, " fetch bus"}, 48'(pm_addr), 48'(a));
        end
        e.rq = rq;
        if (!dual) begin
            e.w = word_of(a, salt);
            e.due = cyc + 1;
        end else if (hit) begin
            e.w = m_w[ix];
            e.due = cyc + 1;
        end else begin
            e.w = word_of(a, salt);
            e.due = cyc + 2;
            m_v[ix] = 1'b1;
            m_t[ix] = tg;
            m_w[ix] = e.w;
        end
        q.push_back(e);
        if (dual && !hit) begin
            @(negedge clk);
            if (junk) begin
                fetch_req    = 1'b1;
                fetch_addr   = a ^ 32'h0000_0044;
                dual_pm_req  = 1'b1;
                dual_pm_addr = 32'hdead_0000;
            end else begin
                fetch_req   = 1'b0;
                dual_pm_req = 1'b0;
            end
            #1;
            chk(pm_rd && !pm_for_data && pm_addr == a, junk ? "R8 refill bus" : "R5 refill bus",
                48'(pm_addr), 48'(a));
            chk(stall == 1'b0, junk ? "R8 refill stall" : "R5 refill stall", 48'(stall), 48'h0);
        end
    endtask

    localparam logic [31:0] A = 32'h1234_0045;
    localparam logic [31:0] B = 32'h9234_0045;

    initial begin
        for (int i = 0; i < 32; i++) m_v[i] = 1'b0;
        do_reset();

        // R2: back-to-back plain fetches
        for (int i = 0; i < 4; i++) do_fetch(32'h0000_0100 + 32'(i), 1'b0, '0, 1'b0, "R2");
        idle(2);

        // R3: plain fetch does not allocate; then R5 miss and R6 hit
        do_fetch(A, 1'b0, '0, 1'b0, "R3 plain");
        idle(1);
        do_fetch(A, 1'b1, 32'h0000_8000, 1'b0, "R3 collision misses");
        idle(1);
        do_fetch(A, 1'b1, 32'h0000_8004, 1'b0, "R6 hit");
        idle(1);

        // R9 and R6: memory changes, plain fetch sees new word, hit keeps old word
        salt = 16'hc3c3;
        do_fetch(A, 1'b0, '0, 1'b0, "R9 plain bypass");
        do_fetch(A, 1'b1, 32'h0000_8008, 1'b0, "R6 stored word");
        idle(1);

        // R7: alias with same index evicts
        do_fetch(B, 1'b1, 32'h0000_9000, 1'b0, "R7 alias miss");
        do_fetch(A, 1'b1, 32'h0000_9004, 1'b0, "R7 evicted miss");
        do_fetch(A, 1'b1, 32'h0000_9008, 1'b0, "R7 refilled hit");
        idle(1);

        // R8: requests inside the refill slot are ignored
        do_fetch(32'h0000_2a13, 1'b1, 32'h0000_a000, 1'b1, "R8 miss");
        idle(1);
        do_fetch(32'h0000_2a13, 1'b1, 32'h0000_a004, 1'b0, "R8 hit after");
        idle(2);

        // R4: data read alone
        @(negedge clk);
        fetch_req    = 1'b0;
        dual_pm_req  = 1'b1;
        dual_pm_addr = 32'h0000_b00c;
        #1;
        chk(pm_rd && pm_for_data && pm_addr == 32'h0000_b00c, "R4 data only", 48'(pm_addr), 48'h0000_b00c);
        idle(2);

        // R5/R6 mix over a small address set
        for (int i = 0; i < 40; i++) begin
            logic [31:0] a;
            a = 32'h0004_0000 + 32'((i * 7) % 12) + ((i % 3 == 0) ? 32'h0010_0000 : 32'h0);
            do_fetch(a, (i % 4) != 3, 32'h0000_c000 + 32'(i), 1'b0, (i % 4) != 3 ? "R5 mix" : "R2 mix");
        end
        idle(3);

        // R1: reset mid-run clears the entries
        do_reset();
        do_fetch(A, 1'b1, 32'h0000_d000, 1'b0, "R1 miss after reset");
        idle(4);

        chk(q.size() == 0, "R2 pending results", 48'(q.size()), 48'h0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule